// File: doc/BRIEF.md
# Two-Speed Angle Acquisition Sequencer

This block runs a fixed, repeating frame that reads two angle converters, one coarse and one fine, over byte-wide buses. Each frame it pulls the converters' inhibit line low, then enables the coarse byte, the upper fine byte and the lower fine byte one after another. Each byte is latched in the middle of its enable pulse.

When the lower fine byte is latched, all three readings move together into a merge step. The merge step builds one 22-bit angle. The fine reading gives the low 16 bits. The coarse byte gives the top 6 bits, after a one-count correction that uses its two overlap bits. The merged angle appears on three tri-state groups, and each group has its own active-low enable.

A hold input blocks the update so that the angle read out stays fixed. The sequencer clock runs at twice the nominal frame clock, so one frame of eight nominal cycles is sixteen sequencer cycles and half-cycle timing stays synchronous.

Top module: `twospeed_angle_seq`

## Requirements
- R1: While reset is asserted and right after it is released, the angle register is zero, and inhibit and all three read enables are high. The first frame begins on the first clock edge after release.
- R2: A frame is 16 sequencer cycles long. Inhibit falls once per frame, stays low for sequencer cycles 0 to 7 of the frame, and stays high for cycles 8 to 15.
- R3: The coarse enable is low only in cycles 1 and 2. The coarse byte is captured on the edge that ends cycle 1.
- R4: The upper fine enable is low only in cycles 3 and 4 and is captured on the edge that ends cycle 3. The lower fine enable is low only in cycles 5 and 6 and is captured on the edge that ends cycle 5. At most one enable is low at any time, and each enable falls on the same edge where the one before it rises.
- R5: The merged angle has the 16-bit fine value (upper byte then lower byte) in bits 15:0. Bits 21:16 are coarse[7:2] plus a correction. Take d = fine[15:14] − coarse[1:0] as a signed integer. If d ≤ −2 the correction is +1. If d ≥ 2 it is −1. Otherwise it is 0. The sum wraps modulo 64.
- R6: The high group carries angle bits 21:14, the middle group bits 13:6 and the low group bits 5:0.
- R7: Each group drives its bits while its own enable is low and is high impedance while that enable is high. The other groups are not affected.
- R8: Hold is sampled on the capture edge of the lower fine byte. If hold is low there, the angle keeps its previous value. Updates resume in the first frame where hold is high at that edge.
- R9: The angle register changes only on the edge that ends cycle 5. The new value is therefore visible while the lower fine enable is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock, twice the nominal frame clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | High allows the angle update; low freezes it |
| coarse_data_i | input | 8 | Coarse converter data bus |
| fine_data_i | input | 8 | Fine converter data bus, upper or lower byte |
| oe_hi_ni | input | 1 | Active-low enable for the high group |
| oe_mid_ni | input | 1 | Active-low enable for the middle group |
| oe_lo_ni | input | 1 | Active-low enable for the low group |
| inhibit_no | output | 1 | Converter inhibit, active low |
| coarse_en_no | output | 1 | Coarse byte read enable, active low |
| fine_msb_en_no | output | 1 | Upper fine byte read enable, active low |
| fine_lsb_en_no | output | 1 | Lower fine byte read enable, active low |
| angle_hi_o | output | 8 | Angle bits 21:14, tri-state |
| angle_mid_o | output | 8 | Angle bits 13:6, tri-state |
| angle_lo_o | output | 6 | Angle bits 5:0, tri-state |

## Verification
The merge is driven with coarse and fine pairs that give no correction, a +1 correction, and a −1 correction. Some of these pairs wrap the top six bits through zero in either direction, which separates modular arithmetic from saturating arithmetic or a correction with the wrong sign.

The converter model puts a filler pattern on each bus whenever that bus's enable is high. A byte captured at the wrong time therefore shows up in the merged angle.

Two frames in a row with hold low, carrying new data, show that the output is frozen. The frame after them shows that updates resume.

Each output group is released in turn while the bench drives a pattern onto it. This shows that the release works and that the groups are independent.

// File: rtl/asq_pkg.sv
package asq_pkg;
  // frame phase positions, in sequencer cycles from the inhibit fall
  localparam int unsigned PH_COARSE = 1;
  localparam int unsigned PH_FMSB   = 3;
  localparam int unsigned PH_FLSB   = 5;
  localparam int unsigned EN_LEN    = 2;
  localparam int unsigned READ_LEN  = 8;

  typedef struct packed {
    logic inhibit_n;
    logic coarse_n;
    logic fmsb_n;
    logic flsb_n;
  } ctl_t;
endpackage

// File: rtl/asq_phase_gen.sv
module asq_phase_gen
  import asq_pkg::*;
#(
  parameter int unsigned FRAME_CYC = 8,
  localparam int unsigned PHASES   = 2 * FRAME_CYC,
  localparam int unsigned PW       = $clog2(PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output ctl_t          ctl_o,
  output logic          cap_coarse_o,
  output logic          cap_fmsb_o,
  output logic          cap_flsb_o
);
  logic [PW-1:0] phase_q, phase_d;
  ctl_t          ctl_d;

  assign phase_d = (phase_q == PW'(PHASES - 1)) ? '0 : phase_q + 1'b1;

  function automatic logic in_win(logic [PW-1:0] p, int unsigned start, int unsigned len);
    return (int'(p) >= int'(start)) && (int'(p) < int'(start + len));
  endfunction

  // decode next phase so the strobes leave flops glitch-free
  always_comb begin
    ctl_d.inhibit_n = !in_win(phase_d, 0, READ_LEN);
    ctl_d.coarse_n  = !in_win(phase_d, PH_COARSE, EN_LEN);
    ctl_d.fmsb_n    = !in_win(phase_d, PH_FMSB, EN_LEN);
    ctl_d.flsb_n    = !in_win(phase_d, PH_FLSB, EN_LEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PW'(PHASES - 1);
      ctl_o   <= '1;
    end else begin
      phase_q <= phase_d;
      ctl_o   <= ctl_d;
    end
  end

  assign cap_coarse_o = (phase_q == PW'(PH_COARSE));
  assign cap_fmsb_o   = (phase_q == PW'(PH_FMSB));
  assign cap_flsb_o   = (phase_q == PW'(PH_FLSB));
endmodule

// File: rtl/asq_merge.sv
module asq_merge #(
  parameter int unsigned COARSE_W = 8,
  parameter int unsigned FINE_W   = 16,
  parameter int unsigned OVL_W    = 2,
  localparam int unsigned TOP_W   = COARSE_W - OVL_W,
  localparam int unsigned ANGLE_W = TOP_W + FINE_W
) (
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic [ANGLE_W-1:0]  angle_o
);
  localparam int THRESH = 1 << (OVL_W - 1);

  logic signed [OVL_W:0] diff;
  logic [TOP_W-1:0]      top;

  always_comb begin
    diff = $signed({1'b0, fine_i[FINE_W-1 -: OVL_W]}) - $signed({1'b0, coarse_i[OVL_W-1:0]});
    top  = coarse_i[COARSE_W-1:OVL_W];
    // fine already crossed the next coarse step, or not yet reached this one
    if (int'(diff) <= -THRESH)     top = top + 1'b1;
    else if (int'(diff) >= THRESH) top = top - 1'b1;
    angle_o = {top, fine_i};
  end
endmodule

// File: rtl/asq_tri_group.sv
module asq_tri_group #(
  parameter int unsigned W = 8
) (
  input  logic         oe_ni,
  input  logic [W-1:0] d_i,
  output wire  [W-1:0] q_o
);
  assign q_o = oe_ni ? {W{1'bz}} : d_i;
endmodule

// File: rtl/twospeed_angle_seq.sv
module twospeed_angle_seq
  import asq_pkg::*;
#(
  parameter int unsigned FRAME_CYC = 8,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned OVL_W     = 2,
  parameter int unsigned LO_W      = 6,
  localparam int unsigned FINE_W   = 2 * BYTE_W,
  localparam int unsigned ANGLE_W  = BYTE_W - OVL_W + FINE_W,
  localparam int unsigned HI_LSB   = ANGLE_W - BYTE_W,
  localparam int unsigned MID_LSB  = LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic [BYTE_W-1:0] coarse_data_i,
  input  logic [BYTE_W-1:0] fine_data_i,
  input  logic              oe_hi_ni,
  input  logic              oe_mid_ni,
  input  logic              oe_lo_ni,
  output logic              inhibit_no,
  output logic              coarse_en_no,
  output logic              fine_msb_en_no,
  output logic              fine_lsb_en_no,
  output wire  [BYTE_W-1:0] angle_hi_o,
  output wire  [BYTE_W-1:0] angle_mid_o,
  output wire  [LO_W-1:0]   angle_lo_o
);
  ctl_t               ctl;
  logic               cap_coarse, cap_fmsb, cap_flsb;
  logic [BYTE_W-1:0]  coarse_q, fmsb_q;
  logic [ANGLE_W-1:0] merged, angle_q;

  asq_phase_gen #(.FRAME_CYC(FRAME_CYC)) u_phase (
    .clk_i, .rst_ni,
    .ctl_o        (ctl),
    .cap_coarse_o (cap_coarse),
    .cap_fmsb_o   (cap_fmsb),
    .cap_flsb_o   (cap_flsb)
  );

  assign inhibit_no     = ctl.inhibit_n;
  assign coarse_en_no   = ctl.coarse_n;
  assign fine_msb_en_no = ctl.fmsb_n;
  assign fine_lsb_en_no = ctl.flsb_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q <= '0;
      fmsb_q   <= '0;
    end else begin
      if (cap_coarse) coarse_q <= coarse_data_i;
      if (cap_fmsb)   fmsb_q   <= fine_data_i;
    end
  end

  // lower fine byte joins the held bytes on the same edge
  asq_merge #(.COARSE_W(BYTE_W), .FINE_W(FINE_W), .OVL_W(OVL_W)) u_merge (
    .coarse_i (coarse_q),
    .fine_i   ({fmsb_q, fine_data_i}),
    .angle_o  (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                angle_q <= '0;
    else if (cap_flsb && hold_i) angle_q <= merged;
  end

  asq_tri_group #(.W(BYTE_W)) u_grp_hi (
    .oe_ni (oe_hi_ni), .d_i (angle_q[HI_LSB +: BYTE_W]), .q_o (angle_hi_o));
  asq_tri_group #(.W(BYTE_W)) u_grp_mid (
    .oe_ni (oe_mid_ni), .d_i (angle_q[MID_LSB +: BYTE_W]), .q_o (angle_mid_o));
  asq_tri_group #(.W(LO_W)) u_grp_lo (
    .oe_ni (oe_lo_ni), .d_i (angle_q[LO_W-1:0]), .q_o (angle_lo_o));
endmodule

module asq_checker #(
  parameter int unsigned FRAME_CYC = 8,
  parameter int unsigned ANGLE_W   = 22
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hold_i,
  input logic               inhibit_no,
  input logic               coarse_en_no,
  input logic               fine_msb_en_no,
  input logic               fine_lsb_en_no,
  input logic [ANGLE_W-1:0] angle_q
);
  localparam int unsigned PHASES = 2 * FRAME_CYC;
  localparam int unsigned GW     = $clog2(PHASES) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q, inh_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      seen_q  <= 1'b0;
      inh_d_q <= 1'b1;
    end else begin
      inh_d_q <= inhibit_no;
      if (inh_d_q && !inhibit_no) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R2: inhibit falls exactly once per frame
  p_frame_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_d_q && !inhibit_no && seen_q) |-> (gap_q == GW'(PHASES - 1)));

  // R3: enables only inside the inhibit window
  p_en_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!coarse_en_no || !fine_msb_en_no || !fine_lsb_en_no) |-> !inhibit_no);

  p_single_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~coarse_en_no, ~fine_msb_en_no, ~fine_lsb_en_no}));

  p_coarse_to_fmsb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coarse_en_no) |-> $fell(fine_msb_en_no));

  p_fmsb_to_flsb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fine_msb_en_no) |-> $fell(fine_lsb_en_no));

  p_hold_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hold_i) |-> $stable(angle_q));

  p_update_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(angle_q) |-> (!fine_lsb_en_no && $past(!fine_lsb_en_no)));
endmodule

bind twospeed_angle_seq asq_checker #(.FRAME_CYC(FRAME_CYC), .ANGLE_W(ANGLE_W)) u_chk (
  .clk_i, .rst_ni, .hold_i, .inhibit_no, .coarse_en_no,
  .fine_msb_en_no, .fine_lsb_en_no, .angle_q
);

// File: tb/twospeed_angle_seq_tb.sv
module twospeed_angle_seq_tb;
  localparam int CLK_PERIOD_NS = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic hold = 1'b1;
  logic oe_hi_n = 1'b0, oe_mid_n = 1'b0, oe_lo_n = 1'b0;
  logic drv_hi = 1'b0, drv_mid = 1'b0, drv_lo = 1'b0;
  logic [7:0]  cur_c = '0;
  logic [15:0] cur_f = '0;
  logic inhibit_n, coarse_en_n, fmsb_en_n, flsb_en_n;
  logic [7:0] coarse_bus, fine_bus;
  wire  [7:0] hi_bus, mid_bus;
  wire  [5:0] lo_bus;

  int n_tests = 0, n_fail = 0;
  logic [21:0] exp_q[$];
  logic [21:0] last_exp = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD_NS / 2) clk = ~clk;

  // converter model: filler on the bus whenever not enabled
  assign coarse_bus = !coarse_en_n ? cur_c : 8'hA5;
  assign fine_bus   = !fmsb_en_n ? cur_f[15:8] : (!flsb_en_n ? cur_f[7:0] : 8'h3C);
  assign hi_bus  = drv_hi  ? 8'h5A : 8'hzz;
  assign mid_bus = drv_mid ? 8'hC3 : 8'hzz;
  assign lo_bus  = drv_lo  ? 6'h2D : 6'hzz;

  twospeed_angle_seq u_dut (
    .clk_i (clk), .rst_ni (rst_n), .hold_i (hold),
    .coarse_data_i (coarse_bus), .fine_data_i (fine_bus),
    .oe_hi_ni (oe_hi_n), .oe_mid_ni (oe_mid_n), .oe_lo_ni (oe_lo_n),
    .inhibit_no (inhibit_n), .coarse_en_no (coarse_en_n),
    .fine_msb_en_no (fmsb_en_n), .fine_lsb_en_no (flsb_en_n),
    .angle_hi_o (hi_bus), .angle_mid_o (mid_bus), .angle_lo_o (lo_bus)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] model(input logic [7:0] c, input logic [15:0] f);
    int top = c >> 2;
    int d = int'(f >> 14) - int'(c & 8'h3);
    if (d <= -2) top = top + 1;
    if (d >= 2)  top = top - 1;
    top = (top + 64) % 64;
    return 22'(top) << 16 | 22'(f);
  endfunction

  task automatic drive(input logic [7:0] c, input logic [15:0] f, input bit h);
    cur_c = c;
    cur_f = f;
    hold  = h;
    if (h) last_exp = model(c, f);   // R5 expected merge; R8 keeps last when low
    exp_q.push_back(last_exp);
  endtask

  // scoreboard monitor: compare after each update window
  initial begin
    forever begin
      @(posedge flsb_en_n);
      @(negedge clk);
      if (rst_n) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected window", 0, 0);
        end else begin
          logic [21:0] e;
          e = exp_q.pop_front();
          check(hi_bus  == e[21:14], "R5/R6/R8 high group", 32'(hi_bus), 32'(e[21:14]));
          check(mid_bus == e[13:6],  "R5/R6/R8 middle group", 32'(mid_bus), 32'(e[13:6]));
          check(lo_bus  == e[5:0],   "R5/R6/R8 low group", 32'(lo_bus), 32'(e[5:0]));
        end
      end
    end
  end

  // frame timing monitor: R2, R3, R4
  initial begin
    int k = -1;
    logic prev_inh = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n || done) begin
        k = -1;
        prev_inh = 1'b1;
      end else begin
        if (prev_inh && !inhibit_n) begin
          if (k != -1) check(k == 15, "R2 frame period", 32'(k + 1), 16);
          k = 0;
        end else if (k >= 0) begin
          k++;
          if (k > 15) check(1'b0, "R2 missing inhibit fall", 32'(k), 15);
        end
        if (k >= 0 && k <= 15) begin
          logic [3:0] ev, av;
          ev = {!(k < 8), !(k == 1 || k == 2), !(k == 3 || k == 4), !(k == 5 || k == 6)};
          av = {inhibit_n, coarse_en_n, fmsb_en_n, flsb_en_n};
          check(av == ev, "R2/R3/R4 strobe pattern", 32'(av), 32'(ev));
        end
        prev_inh = inhibit_n;
      end
    end
  end

  initial begin
    #(CLK_PERIOD_NS * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    drive(8'h8D, 16'h5123, 1'b1);   // no correction
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check({hi_bus, mid_bus, lo_bus} == 22'h0, "R1 angle zero", 32'({hi_bus, mid_bus, lo_bus}), 0);
    check({inhibit_n, coarse_en_n, fmsb_en_n, flsb_en_n} == 4'hF, "R1 strobes idle",
          32'({inhibit_n, coarse_en_n, fmsb_en_n, flsb_en_n}), 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check(!inhibit_n, "R1 frame starts after release", 32'(inhibit_n), 0);

    @(posedge inhibit_n); drive(8'h0F, 16'h0123, 1'b1);   // +1
    @(posedge inhibit_n); drive(8'h10, 16'hF000, 1'b1);   // -1
    @(posedge inhibit_n); drive(8'h00, 16'hC000, 1'b1);   // -1 wraps to 63
    @(posedge inhibit_n); drive(8'hFA, 16'h0000, 1'b1);   // +1 at d=-2
    @(posedge inhibit_n); drive(8'hFF, 16'h0000, 1'b1);   // +1 wraps to 0
    @(posedge inhibit_n); drive(8'hFE, 16'h4000, 1'b1);   // d=-1 no correction
    @(posedge inhibit_n); drive(8'h22, 16'h8888, 1'b0);   // R8 held
    @(posedge inhibit_n); drive(8'h33, 16'h1111, 1'b0);   // R8 held
    @(posedge inhibit_n); drive(8'hB6, 16'h9ABC, 1'b1);   // R8 resumes
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);

    // R7: release one group at a time, bench drives a pattern on it
    @(negedge clk); oe_hi_n = 1'b1; drv_hi = 1'b1;
    #2;
    check(hi_bus == 8'h5A, "R7 high released", 32'(hi_bus), 32'h5A);
    check(mid_bus == last_exp[13:6], "R7 middle still driven", 32'(mid_bus), 32'(last_exp[13:6]));
    @(negedge clk); drv_hi = 1'b0; oe_hi_n = 1'b0; oe_mid_n = 1'b1; drv_mid = 1'b1;
    #2;
    check(mid_bus == 8'hC3, "R7 middle released", 32'(mid_bus), 32'hC3);
    check(hi_bus == last_exp[21:14], "R7 high driven again", 32'(hi_bus), 32'(last_exp[21:14]));
    @(negedge clk); drv_mid = 1'b0; oe_mid_n = 1'b0; oe_lo_n = 1'b1; drv_lo = 1'b1;
    #2;
    check(lo_bus == 6'h2D, "R7 low released", 32'(lo_bus), 32'h2D);
    check(mid_bus == last_exp[13:6], "R7 middle driven again", 32'(mid_bus), 32'(last_exp[13:6]));
    @(negedge clk); drv_lo = 1'b0; oe_lo_n = 1'b0;
    #2;
    check(lo_bus == last_exp[5:0], "R7 low driven again", 32'(lo_bus), 32'(last_exp[5:0]));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule